// File: doc/BRIEF.md
# Packet DMA Bus Burst Planner

This block is the bus-side sequencer of a packet DMA channel. A request supplies a start word address, a byte count, the pipe kind (bulk or isochronous) and the programmed maximum packet size. The block then drives a word-wide bus master address phase. It issues sequential word beats in bursts of undefined length. It cuts a burst whenever a cap is reached, and it restarts cleanly after a wait state or a lost grant. Descriptor fetches and packet data moves use the same request port and follow the same burst rules.

The cap on one burst is the smallest of five limits:
- the absolute limit of 256 beats;
- the pipe-kind limit, which is 128 beats for bulk and 256 for isochronous;
- the packet size in words;
- the words left before the next 1 KB address boundary;
- the words still left in the buffer.

An optional lock mode keeps the master lock line high from the first beat to the end of the last data phase. While it is held, no other master can open a different memory row in the middle of the buffer.

Top module: `pkt_dma_burst_planner`

## Requirements
- R1: Every beat moves one 32-bit word. The byte address starts at 4 × the start word address and rises by 4 with each accepted beat across the whole buffer. The burst type reads 3'b001 (incrementing, undefined length) while a beat is presented and 3'b000 otherwise.
- R2: The transfer codes are 2'b00 for idle, 2'b10 for the first beat of a burst and 2'b11 for each following beat. The first beat appears no earlier than the cycle after the start pulse.
- R3: While the ready input is low, the transfer code, the address and the lock output hold their values.
- R4: No burst continues across a 1 KB boundary. A beat whose byte address is a multiple of 1024 is always the first beat of a burst.
- R5: A burst holds at most 128 beats on a bulk pipe and at most 256 beats on an isochronous pipe.
- R6: A burst holds at most ceil(packet bytes / 4) beats. A packet size of 0 is treated as one word.
- R7: While the grant stays high, every burst is exactly as long as the smallest of its limits: 256, the pipe-kind limit, the packet words, the words to the next 1 KB boundary and the words left.
- R8: When the grant is low at an edge where a beat would be issued, the bus goes idle. The remaining words resume with a first-beat code (2'b10) once the grant returns.
- R9: A buffer of N bytes takes exactly ceil(N/4) beats. A request of 0 bytes issues no beat and pulses done in the cycle after the start.
- R10: Done is a one-cycle pulse. It is raised in the cycle after the ready edge that completes the last beat's data phase.
- R11: With lock mode on, the lock output rises together with the first beat's address phase, stays high through the final data phase, and is low in the done cycle. With lock mode off, the lock output never rises.
- R12: Busy is high from the cycle after an accepted start until the done cycle. A start pulse while busy is ignored.
- R13: After reset, the bus is idle and lock, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only while not busy |
| start_waddr_i | input | AW | Start word address |
| len_bytes_i | input | LEN_W | Buffer length in bytes |
| iso_i | input | 1 | 1 = isochronous pipe, 0 = bulk pipe |
| pkt_bytes_i | input | PKT_W | Programmed maximum packet size in bytes |
| lock_en_i | input | 1 | Hold the bus lock for the whole buffer |
| hgrant_i | input | 1 | Bus grant; low means the grant is lost |
| hready_i | input | 1 | Bus ready; low inserts a wait state |
| haddr_o | output | AW+2 | Byte address of the current beat |
| htrans_o | output | 2 | Transfer code |
| hburst_o | output | 3 | Burst type |
| hmastlock_o | output | 1 | Master lock |
| busy_o | output | 1 | Buffer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The tests start buffers at a 1 KB-aligned address and at a word offset of 200. Comparing the two shows whether the 1 KB cut is taken from the current address or from the start of the buffer. Runs that pair bulk and isochronous pipes with large packet sizes separate the pipe-kind cap from the packet cap. Packet sizes of 10 and 0 bytes show that the packet cap rounds up to whole words and is clamped to at least one word. The remaining runs use odd byte counts and a zero length, random ready stalls with lock on, random grant drops, and a start pulse during a busy run. These show the rounding of the word count, the hold behaviour, the restart with a first-beat code, and that a second request is ignored.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } plan_st_e;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;

  localparam int CAP_W         = 9;
  localparam int KB_WORD_BITS  = 8;
  localparam int ABS_MAX_BEATS = 256;
  localparam int BULK_BEATS    = 128;
  localparam int ISO_BEATS     = 256;

endpackage

// File: rtl/pdma_word_ceil.sv
module pdma_word_ceil #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] bytes_i,
  output logic [IN_W-2:0] words_o
);

  logic [IN_W-2:0] whole_words;
  logic [IN_W-2:0] part_word;

  assign whole_words = {1'b0, bytes_i[IN_W-1:2]};
  assign part_word   = {{(IN_W-2){1'b0}}, |bytes_i[1:0]};
  assign words_o     = whole_words + part_word;

endmodule

// File: rtl/pdma_burst_cap.sv
module pdma_burst_cap
  import pdma_pkg::*;
#(
  parameter int WCNT_W = 15,
  parameter int PKTW_W = 10
) (
  input  logic [KB_WORD_BITS-1:0] ptr_lo_i,
  input  logic [WCNT_W-1:0]       words_left_i,
  input  logic                    iso_i,
  input  logic [PKTW_W-1:0]       pkt_words_i,
  output logic [CAP_W-1:0]        cap_o
);

  localparam int NCAND = 4;
  localparam logic [CAP_W-1:0] ABS_CAP  = CAP_W'(ABS_MAX_BEATS);
  localparam logic [CAP_W-1:0] KB_SPAN  = CAP_W'(1 << KB_WORD_BITS);

  logic [CAP_W-1:0] cand    [NCAND];
  logic [CAP_W-1:0] run_min [NCAND+1];

  logic [CAP_W-1:0] left_sat;
  logic [CAP_W-1:0] pkt_sat;

  always_comb begin
    if (32'(words_left_i) > 32'(ABS_MAX_BEATS)) left_sat = ABS_CAP;
    else                                        left_sat = CAP_W'(words_left_i);
    if (pkt_words_i == '0)                            pkt_sat = CAP_W'(1);
    else if (32'(pkt_words_i) > 32'(ABS_MAX_BEATS))   pkt_sat = ABS_CAP;
    else                                              pkt_sat = CAP_W'(pkt_words_i);
  end

  assign cand[0] = iso_i ? CAP_W'(ISO_BEATS) : CAP_W'(BULK_BEATS);
  assign cand[1] = pkt_sat;
  assign cand[2] = KB_SPAN - {1'b0, ptr_lo_i};
  assign cand[3] = left_sat;

  assign run_min[0] = ABS_CAP;

  genvar g;
  generate
    for (g = 0; g < NCAND; g++) begin : g_min
      assign run_min[g+1] = (cand[g] < run_min[g]) ? cand[g] : run_min[g];
    end
  endgenerate

  assign cap_o = run_min[NCAND];

endmodule

// File: rtl/pdma_bus_lock.sv
module pdma_bus_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  input  logic lock_mode_i,
  input  logic first_beat_i,
  input  logic last_data_i,
  output logic lock_o
);

  logic lock_q;
  logic lock_d;

  always_comb begin
    lock_d = lock_q;
    if (advance_i) begin
      if (last_data_i)                      lock_d = 1'b0;
      else if (first_beat_i && lock_mode_i) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign lock_o = lock_q;

  AST_LOCK_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_mode_i |-> !lock_q); // R11

  AST_LOCK_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && last_data_i) |=> !lock_q); // R11

endmodule

// File: rtl/pkt_dma_burst_planner.sv
module pkt_dma_burst_planner
  import pdma_pkg::*;
#(
  parameter int AW    = 30,
  parameter int LEN_W = 16,
  parameter int PKT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    start_waddr_i,
  input  logic [LEN_W-1:0] len_bytes_i,
  input  logic             iso_i,
  input  logic [PKT_W-1:0] pkt_bytes_i,
  input  logic             lock_en_i,
  input  logic             hgrant_i,
  input  logic             hready_i,
  output logic [AW+1:0]    haddr_o,
  output logic [1:0]       htrans_o,
  output logic [2:0]       hburst_o,
  output logic             hmastlock_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int WCNT_W = LEN_W - 1;
  localparam int PKTW_W = PKT_W - 1;
  localparam int BL_W   = CAP_W - 1;

  plan_st_e          st_q, st_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [AW-1:0]     haddr_q, haddr_d;
  htrans_e           htrans_q, htrans_d;
  logic [WCNT_W-1:0] words_q, words_d;
  logic [BL_W-1:0]   burst_q, burst_d;
  logic              iso_q, iso_d;
  logic [PKTW_W-1:0] pkt_q, pkt_d;
  logic              lockmode_q, lockmode_d;
  logic              started_q, started_d;
  logic              tail_a_q, tail_a_d;
  logic              tail_d_q, tail_d_d;
  logic              done_q, done_d;

  logic [WCNT_W-1:0] len_words;
  logic [PKTW_W-1:0] pkt_words;
  logic [CAP_W-1:0]  cap;
  logic              issue_ok;
  logic              continue_burst;
  logic              first_beat;
  logic              last_data;

  pdma_word_ceil #(.IN_W(LEN_W)) i_len_ceil (
    .bytes_i (len_bytes_i),
    .words_o (len_words)
  );

  pdma_word_ceil #(.IN_W(PKT_W)) i_pkt_ceil (
    .bytes_i (pkt_bytes_i),
    .words_o (pkt_words)
  );

  pdma_burst_cap #(.WCNT_W(WCNT_W), .PKTW_W(PKTW_W)) i_cap (
    .ptr_lo_i     (ptr_q[KB_WORD_BITS-1:0]),
    .words_left_i (words_q),
    .iso_i        (iso_q),
    .pkt_words_i  (pkt_q),
    .cap_o        (cap)
  );

  assign issue_ok       = (st_q == ST_RUN) && (words_q != '0) && hgrant_i;
  assign continue_burst = (htrans_q != HT_IDLE) && (burst_q != '0);
  assign first_beat     = hready_i && issue_ok && !started_q;
  assign last_data      = (st_q == ST_RUN) && tail_d_q;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    haddr_d    = haddr_q;
    htrans_d   = htrans_q;
    words_d    = words_q;
    burst_d    = burst_q;
    iso_d      = iso_q;
    pkt_d      = pkt_q;
    lockmode_d = lockmode_q;
    started_d  = started_q;
    tail_a_d   = tail_a_q;
    tail_d_d   = tail_d_q;
    done_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (len_words == '0) begin
            done_d = 1'b1;
          end else begin
            st_d       = ST_RUN;
            ptr_d      = start_waddr_i;
            words_d    = len_words;
            iso_d      = iso_i;
            pkt_d      = pkt_words;
            lockmode_d = lock_en_i;
            started_d  = 1'b0;
            tail_a_d   = 1'b0;
            tail_d_d   = 1'b0;
          end
        end
      end
      ST_RUN: begin
        if (hready_i) begin
          tail_d_d = tail_a_q;
          if (tail_d_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
          if (issue_ok) begin
            haddr_d   = ptr_q;
            ptr_d     = ptr_q + AW'(1);
            words_d   = words_q - WCNT_W'(1);
            started_d = 1'b1;
            tail_a_d  = (words_q == WCNT_W'(1));
            if (continue_burst) begin
              htrans_d = HT_SEQ;
              burst_d  = burst_q - BL_W'(1);
            end else begin
              htrans_d = HT_NONSEQ;
              burst_d  = BL_W'(cap - CAP_W'(1));
            end
          end else begin
            htrans_d = HT_IDLE;
            tail_a_d = 1'b0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      haddr_q    <= '0;
      htrans_q   <= HT_IDLE;
      words_q    <= '0;
      burst_q    <= '0;
      iso_q      <= 1'b0;
      pkt_q      <= '0;
      lockmode_q <= 1'b0;
      started_q  <= 1'b0;
      tail_a_q   <= 1'b0;
      tail_d_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      haddr_q    <= haddr_d;
      htrans_q   <= htrans_d;
      words_q    <= words_d;
      burst_q    <= burst_d;
      iso_q      <= iso_d;
      pkt_q      <= pkt_d;
      lockmode_q <= lockmode_d;
      started_q  <= started_d;
      tail_a_q   <= tail_a_d;
      tail_d_q   <= tail_d_d;
      done_q     <= done_d;
    end
  end

  pdma_bus_lock i_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance_i    (hready_i),
    .lock_mode_i  (lockmode_q),
    .first_beat_i (first_beat),
    .last_data_i  (last_data),
    .lock_o       (hmastlock_o)
  );

  assign haddr_o  = {haddr_q, 2'b00};
  assign htrans_o = htrans_q;
  assign hburst_o = (htrans_q != HT_IDLE) ? HB_INCR : HB_SINGLE;
  assign busy_o   = (st_q == ST_RUN);
  assign done_o   = done_q;

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_i && htrans_q != HT_IDLE) |=> ($stable(htrans_q) && $stable(haddr_q))); // R3

  AST_SEQ_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == HT_SEQ) |-> ($past(htrans_q) != HT_IDLE)); // R2

  AST_SEQ_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_i && htrans_q != HT_IDLE) |=> (htrans_q != HT_SEQ || haddr_q == $past(haddr_q) + AW'(1))); // R1

  AST_NO_KB_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == HT_SEQ) |-> (haddr_q[KB_WORD_BITS-1:0] != '0)); // R4

  AST_TYPE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q != HT_IDLE) |-> (burst_q <= (iso_q ? BL_W'(ISO_BEATS - 1) : BL_W'(BULK_BEATS - 1)))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (htrans_q == HT_IDLE && !hmastlock_o)); // R12

endmodule

// File: tb/test_pkt_dma_burst_planner.sv
module test_pkt_dma_burst_planner;

  localparam int AW    = 30;
  localparam int LEN_W = 16;
  localparam int PKT_W = 11;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [AW-1:0]    start_waddr_i;
  logic [LEN_W-1:0] len_bytes_i;
  logic             iso_i;
  logic [PKT_W-1:0] pkt_bytes_i;
  logic             lock_en_i;
  logic             hgrant_i;
  logic             hready_i;
  logic [AW+1:0]    haddr_o;
  logic [1:0]       htrans_o;
  logic [2:0]       hburst_o;
  logic             hmastlock_o;
  logic             busy_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;

  pkt_dma_burst_planner #(.AW(AW), .LEN_W(LEN_W), .PKT_W(PKT_W)) i_pkt_dma_burst_planner (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_waddr_i (start_waddr_i),
    .len_bytes_i (len_bytes_i), .iso_i (iso_i), .pkt_bytes_i (pkt_bytes_i),
    .lock_en_i (lock_en_i), .hgrant_i (hgrant_i), .hready_i (hready_i),
    .haddr_o (haddr_o), .htrans_o (htrans_o), .hburst_o (hburst_o),
    .hmastlock_o (hmastlock_o), .busy_o (busy_o), .done_o (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int  m_busy, m_ptr, m_left, m_room, m_trans, m_addr, m_lock, m_done;
  int  m_tail_a, m_tail_d, m_iso, m_pktw, m_lockmode, m_started;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int burst_limit(input int ptr, input int left, input int iso, input int pktw);
    int lim;
    lim = 256;
    lim = imin(lim, iso ? 256 : 128);
    lim = imin(lim, (pktw == 0) ? 1 : pktw);
    lim = imin(lim, 256 - (ptr % 256));
    lim = imin(lim, left);
    return lim;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ptr = 0; m_left = 0; m_room = 0; m_trans = 0; m_addr = 0;
      m_lock = 0; m_done = 0; m_tail_a = 0; m_tail_d = 0; m_iso = 0; m_pktw = 0;
      m_lockmode = 0; m_started = 0;
    end else if (m_busy == 0) begin
      m_done = 0;
      if (start_i) begin
        if ((int'(len_bytes_i) + 3) / 4 == 0) m_done = 1;
        else begin
          m_busy = 1; m_ptr = int'(start_waddr_i); m_left = (int'(len_bytes_i) + 3) / 4;
          m_iso = int'(iso_i); m_pktw = (int'(pkt_bytes_i) + 3) / 4;
          m_lockmode = int'(lock_en_i); m_started = 0; m_tail_a = 0; m_tail_d = 0;
        end
      end
    end else if (hready_i) begin
      m_done = 0;
      if (m_tail_d != 0) begin m_done = 1; m_busy = 0; m_lock = 0; end
      m_tail_d = m_tail_a;
      if (m_left > 0 && hgrant_i) begin
        if (m_trans != 0 && m_room > 0) begin
          m_trans = 3; m_room = m_room - 1;
        end else begin
          m_trans = 2; m_room = burst_limit(m_ptr, m_left, m_iso, m_pktw) - 1;
        end
        m_addr = m_ptr; m_ptr = m_ptr + 1; m_left = m_left - 1;
        m_tail_a = (m_left == 0) ? 1 : 0;
        if (m_started == 0 && m_lockmode != 0) m_lock = 1;
        m_started = 1;
      end else begin
        m_trans = 0; m_tail_a = 0;
      end
    end else begin
      m_done = 0;
    end
  end

  // Burst monitor on the bus outputs
  int bl[$];
  int cur_len;
  int open_burst;
  int prev_idle;
  int cur_iso, cur_pktw;

  always @(posedge clk) begin
    if (rst_n && hready_i) begin
      if (htrans_o == 2'b10 || htrans_o == 2'b00) begin
        if (open_burst != 0) begin
          bl.push_back(cur_len);
          check("R5 burst within pipe-kind cap", cur_len > (cur_iso ? 256 : 128), 0);
          check("R6 burst within packet cap", cur_len > ((cur_pktw == 0) ? 1 : cur_pktw), 0);
          open_burst = 0;
        end
        if (htrans_o == 2'b10) begin open_burst = 1; cur_len = 1; end
      end else if (htrans_o == 2'b11) begin
        cur_len++;
        check("R4 continuation beat off 1KB boundary", (haddr_o % 1024) == 0, 0);
        check("R8 continuation never follows idle", prev_idle, 0);
      end
      prev_idle = (htrans_o == 2'b00) ? 1 : 0;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 htrans", htrans_o, m_trans);
      check("R1 haddr", haddr_o, longint'(m_addr) * 4);
      check("R1 hburst", hburst_o, (m_trans != 0) ? 1 : 0);
      check("R11 hmastlock", hmastlock_o, m_lock);
      check("R10 done", done_o, m_done);
      check("R12 busy", busy_o, m_busy);
    end
  end

  function automatic int sum_bl();
    int s = 0;
    foreach (bl[i]) s += bl[i];
    return s;
  endfunction

  task automatic xfer(input int waddr, input int len, input bit iso, input int pkt, input bit lk,
                      input int rdy_pct, input int gnt_pct, input int poke);
    int cyc;
    bl.delete();
    cur_iso = iso; cur_pktw = (pkt + 3) / 4;
    @(negedge clk);
    start_i = 1'b1; start_waddr_i = AW'(waddr); len_bytes_i = LEN_W'(len);
    iso_i = iso; pkt_bytes_i = PKT_W'(pkt); lock_en_i = lk;
    @(negedge clk);
    start_i = 1'b0;
    if (len == 0) begin
      check("R9 zero length done next cycle", done_o, 1);
      check("R9 zero length not busy", busy_o, 0);
    end else begin
      check("R12 busy after start", busy_o, 1);
      check("R2 no beat on start edge", htrans_o, 0);
    end
    cyc = 0;
    while (done_o == 1'b0 && cyc < 30000) begin
      hready_i = ($urandom_range(99) < rdy_pct);
      hgrant_i = ($urandom_range(99) < gnt_pct);
      if (cyc == poke) begin
        start_i = 1'b1; start_waddr_i = AW'(777); len_bytes_i = LEN_W'(40);
        iso_i = ~iso; pkt_bytes_i = PKT_W'(8); lock_en_i = ~lk;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; hready_i = 1'b1; hgrant_i = 1'b1;
    check("R10 done seen", done_o, 1);
    check("R9 beat count", sum_bl(), (len + 3) / 4);
    @(negedge clk);
    check("R10 done single cycle", done_o, 0);
    check("R11 lock low after buffer", hmastlock_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_waddr_i = '0; len_bytes_i = '0; iso_i = 1'b0;
    pkt_bytes_i = '0; lock_en_i = 1'b0; hgrant_i = 1'b1; hready_i = 1'b1;
    open_burst = 0; cur_len = 0; prev_idle = 1; cur_iso = 0; cur_pktw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset htrans idle", htrans_o, 0);
    check("R13 reset lock low", hmastlock_o, 0);
    check("R13 reset busy low", busy_o, 0);
    check("R13 reset done low", done_o, 0);

    xfer(0, 1024, 1'b0, 512, 1'b1, 100, 100, -1);
    check("R5 bulk first burst", bl.size() > 0 ? bl[0] : -1, 128);
    check("R5 bulk burst count", bl.size(), 2);

    xfer(256, 1024, 1'b1, 1023, 1'b0, 100, 100, -1);
    check("R5 iso full burst", bl.size() > 0 ? bl[0] : -1, 256);

    xfer(200, 1600, 1'b1, 1024, 1'b1, 100, 100, -1);
    check("R4 cut before boundary", bl.size() > 0 ? bl[0] : -1, 56);
    check("R7 full span after boundary", bl.size() > 1 ? bl[1] : -1, 256);
    check("R7 remainder burst", bl.size() > 2 ? bl[2] : -1, 88);

    xfer(10, 200, 1'b0, 10, 1'b0, 100, 100, -1);
    check("R6 packet cap rounds up", bl.size() > 0 ? bl[0] : -1, 3);
    check("R7 last burst is remainder", bl.size() > 0 ? bl[bl.size()-1] : -1, 2);

    xfer(5, 20, 1'b0, 0, 1'b0, 100, 100, -1);
    check("R6 zero packet size one word", bl.size() > 0 ? bl[0] : -1, 1);

    xfer(3, 13, 1'b0, 64, 1'b1, 100, 100, -1);
    check("R9 partial word rounded", bl.size() > 0 ? bl[0] : -1, 4);

    xfer(0, 0, 1'b0, 64, 1'b1, 100, 100, -1);

    xfer(100, 2000, 1'b1, 1024, 1'b1, 60, 100, -1);
    xfer(300, 2000, 1'b0, 512, 1'b1, 80, 70, -1);
    xfer(40, 3000, 1'b0, 256, 1'b0, 85, 85, -1);

    xfer(900, 800, 1'b1, 1024, 1'b1, 100, 100, 5);
    check("R12 ignored start leaves first buffer", bl.size() > 0 ? bl[0] : -1, 124);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule